// File: doc/BRIEF.md
# SMBus Register-Access Command Decoder

This block sits behind an SMBus/I2C slave bit engine and works on whole bytes. The engine reports start conditions, a matched slave address with its direction bit, each received byte and stop conditions. The block also receives a pulse each time the master takes a read byte. It collects the bytes of each write transaction and, when the stop arrives, acts on the transaction according to how many bytes it held and the value of the first (command) byte. A single command byte moves a register pointer. A command byte followed by one data byte writes the local register file, or programs one byte of nonvolatile storage. A command byte followed by two data bytes sets the nonvolatile address.

One command value, 0xFE, arriving alone as the first byte, asks for a page of nonvolatile storage to be erased. It acts the moment the byte is received, without waiting for the stop. From then until the storage controller reports completion, the block refuses every access. Reads return the register at the pointer, and the pointer steps forward after each byte the master takes.

Top module: `smbus_cmd_decoder`

## Requirements
- R1: After reset the pointer is 0x00, `ee_addr` is 0xF800, `erase_busy` is 0, `ack_out` is 1, all registers read 0x00 and no pulse output is high.
- R2: A write transaction of exactly one byte whose value is 0x00..0xDF loads `ptr` with that value in the cycle after the stop. A single byte of any other value leaves `ptr` unchanged.
- R3: A write transaction of exactly two bytes whose first byte is 0x00..0xDF stores the second byte at that register address. In the cycle after the stop, `ram_we` is high for one cycle, with `ram_waddr`/`ram_wdata` giving the address and the data.
- R4: `rd_byte` always shows the register at `ptr`. Each `rd_take` while addressed for read advances `ptr` by one, and 0xDF wraps to 0x00.
- R5: A write transaction of exactly three bytes whose first byte is 0xF8..0xFB sets `ee_addr` to {first byte, second byte}, with `ee_addr_ld` high for one cycle after the stop. The third byte has no effect.
- R6: A write transaction of exactly two bytes whose first byte is 0xF8..0xFB pulses `ee_prog` for one cycle after the stop, with `ee_prog_addr` equal to the current `ee_addr` and `ee_prog_data` equal to the second byte. `ee_addr` then advances by one within its low 10 bits, so 0xFBFF becomes 0xF800.
- R7: A first write byte of 0xFE, with bit 2 of register 0x90 set, pulses `ee_erase` and raises `erase_busy` in the next cycle. `ee_erase_page` then carries bits 9..5 of `ee_addr`. With that bit clear, 0xFE is an ordinary byte and causes no erase.
- R8: While `erase_busy` is 1, `ack_out` is 0 and every start, address, byte, stop and read-take event is ignored. An `erase_done` pulse clears `erase_busy`, and while not busy `ack_out` is 1.
- R9: A repeated start before the stop, or a write transaction of more than three bytes, discards the collected bytes with no write, load or program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | Start or repeated start seen |
| evt_addr | input | 1 | Own slave address matched |
| evt_rnw | input | 1 | Direction bit with `evt_addr` (1 = read) |
| evt_byte | input | 1 | A byte was received from the master |
| rx_byte | input | 8 | Received byte value |
| evt_stop | input | 1 | Stop condition seen |
| rd_take | input | 1 | Master consumed the current read byte |
| erase_done | input | 1 | Storage controller finished the erase |
| ack_out | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_byte | output | 8 | Register at the pointer |
| ptr | output | 8 | Register pointer |
| ram_we | output | 1 | Register write pulse |
| ram_waddr | output | 8 | Address of the register write |
| ram_wdata | output | 8 | Data of the register write |
| ee_addr | output | 16 | Current nonvolatile address |
| ee_addr_ld | output | 1 | Nonvolatile address was loaded |
| ee_prog | output | 1 | Byte-program request pulse |
| ee_prog_addr | output | 16 | Address to program |
| ee_prog_data | output | 8 | Byte to program |
| ee_erase | output | 1 | Page-erase request pulse |
| ee_erase_page | output | 5 | Page to erase |
| erase_busy | output | 1 | Erase in progress |

## Verification
The assertions assume that the bit engine reports at most one event per cycle. They also assume that `erase_done` arrives only while an erase is pending, and that `rd_take` comes only after a read address phase. The pointer-stability and busy-hold properties depend on these conditions. The stimulus drives every start, address, byte, stop and take in a cycle of its own, and raises `erase_done` only after the erase pulse has been seen. The stimulus also deliberately sends events while busy, to show that they are dropped.

// File: rtl/smbd_pkg.sv
package smbd_pkg;

    localparam int          BYTE_W        = 8;
    localparam logic [7:0]  RAM_LAST_DEF  = 8'hDF;
    localparam logic [7:0]  EE_HI_MIN     = 8'hF8;
    localparam logic [7:0]  EE_HI_MAX     = 8'hFB;
    localparam logic [7:0]  ERASE_CMD     = 8'hFE;
    localparam logic [7:0]  CFG_ADDR_DEF  = 8'h90;
    localparam int          CFG_ERASE_BIT = 2;
    localparam int          EE_ADDR_W     = 16;
    localparam int          EE_OFS_W      = 10;
    localparam int          EE_PAGE_W     = 5;
    localparam logic [15:0] EE_BASE       = 16'hF800;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_PTR,
        ACT_RAMWR,
        ACT_EEPROG,
        ACT_EEADDR
    } act_e;

    typedef struct packed {
        act_e                kind;
        logic [BYTE_W-1:0]   cmd;
        logic [BYTE_W-1:0]   arg;
    } act_t;

    function automatic logic is_ee_hi(input logic [BYTE_W-1:0] b);
        return (b >= EE_HI_MIN) && (b <= EE_HI_MAX);
    endfunction

    function automatic logic [EE_ADDR_W-1:0] ee_step(input logic [EE_ADDR_W-1:0] a);
        logic [EE_ADDR_W-1:0] r;
        r = a;
        r[EE_OFS_W-1:0] = a[EE_OFS_W-1:0] + {{(EE_OFS_W-1){1'b0}}, 1'b1};
        return r;
    endfunction

    function automatic logic [EE_PAGE_W-1:0] ee_page(input logic [EE_ADDR_W-1:0] a);
        return a[EE_OFS_W-1 -: EE_PAGE_W];
    endfunction

endpackage

// File: rtl/smbd_collector.sv
module smbd_collector
    import smbd_pkg::*;
#(
    parameter int         MAX_BYTES = 3,
    parameter logic [7:0] RAM_LAST  = RAM_LAST_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_addr,
    input  logic              ev_rnw,
    input  logic              ev_byte,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ev_stop,
    input  logic              abort,
    output logic              wr_active,
    output logic              rd_active,
    output logic              first_byte,
    output act_t              act
);

    localparam int             CNT_W   = $clog2(MAX_BYTES + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BYTES + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              wr_q;
    logic              rd_q;
    logic [BYTE_W-1:0] hold_q [MAX_BYTES];
    logic              take;

    assign take = ev_byte && wr_q && !ev_start && !ev_addr && !ev_stop && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            wr_q  <= 1'b0;
            rd_q  <= 1'b0;
        end else if (ev_start) begin
            cnt_q <= '0;
            wr_q  <= 1'b0;
            rd_q  <= 1'b0;
        end else if (ev_addr) begin
            cnt_q <= '0;
            wr_q  <= !ev_rnw;
            rd_q  <= ev_rnw;
        end else if (ev_stop) begin
            cnt_q <= '0;
            wr_q  <= 1'b0;
            rd_q  <= 1'b0;
        end else if (abort) begin
            cnt_q <= '0;
            wr_q  <= 1'b0;
        end else if (take && cnt_q != CNT_SAT) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[i] <= '0;
            end else if (take && cnt_q == CNT_W'(i)) begin
                hold_q[i] <= rx_byte;
            end
        end
    end

    assign wr_active  = wr_q;
    assign rd_active  = rd_q;
    assign first_byte = (cnt_q == '0);

    always_comb begin
        act.kind = ACT_NONE;
        act.cmd  = hold_q[0];
        act.arg  = hold_q[1];
        if (ev_stop && wr_q && !ev_start && !ev_addr) begin
            if (cnt_q == CNT_W'(1)) begin
                if (hold_q[0] <= RAM_LAST) act.kind = ACT_PTR;
            end else if (cnt_q == CNT_W'(2)) begin
                if (hold_q[0] <= RAM_LAST)      act.kind = ACT_RAMWR;
                else if (is_ee_hi(hold_q[0]))   act.kind = ACT_EEPROG;
            end else if (cnt_q == CNT_W'(3)) begin
                if (is_ee_hi(hold_q[0]))        act.kind = ACT_EEADDR;
            end
        end
    end

endmodule

// File: rtl/smbd_ptr.sv
module smbd_ptr #(
    parameter int           W    = 8,
    parameter logic [W-1:0] LAST = 8'hDF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] ptr
);

    logic [W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ld) begin
            ptr_q <= ld_val;
        end else if (inc) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + W'(1);
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/smbd_regfile.sv
module smbd_regfile #(
    parameter int            W        = 8,
    parameter int            AW       = 8,
    parameter int            DEPTH    = 224,
    parameter logic [AW-1:0] CFG_ADDR = 8'h90
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  cfg
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we && (int'(waddr) < DEPTH)) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem_q[raddr] : '0;
    assign cfg   = mem_q[CFG_ADDR];

endmodule

// File: rtl/smbus_cmd_decoder.sv
module smbus_cmd_decoder
    import smbd_pkg::*;
#(
    parameter logic [7:0] RAM_LAST  = RAM_LAST_DEF,
    parameter logic [7:0] CFG_ADDR  = CFG_ADDR_DEF,
    parameter int         CFG_BIT   = CFG_ERASE_BIT,
    parameter int         MAX_BYTES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 evt_start,
    input  logic                 evt_addr,
    input  logic                 evt_rnw,
    input  logic                 evt_byte,
    input  logic [BYTE_W-1:0]    rx_byte,
    input  logic                 evt_stop,
    input  logic                 rd_take,
    input  logic                 erase_done,
    output logic                 ack_out,
    output logic [BYTE_W-1:0]    rd_byte,
    output logic [BYTE_W-1:0]    ptr,
    output logic                 ram_we,
    output logic [BYTE_W-1:0]    ram_waddr,
    output logic [BYTE_W-1:0]    ram_wdata,
    output logic [EE_ADDR_W-1:0] ee_addr,
    output logic                 ee_addr_ld,
    output logic                 ee_prog,
    output logic [EE_ADDR_W-1:0] ee_prog_addr,
    output logic [BYTE_W-1:0]    ee_prog_data,
    output logic                 ee_erase,
    output logic [EE_PAGE_W-1:0] ee_erase_page,
    output logic                 erase_busy
);

    localparam int DEPTH = int'(RAM_LAST) + 1;

    logic                 busy_q;
    logic                 open_q;
    logic                 g_start, g_addr, g_byte, g_stop, g_take;
    logic                 wr_active, rd_active, first_byte;
    act_t                 act;
    logic                 erase_fire;
    logic [BYTE_W-1:0]    cfg_byte;
    logic [BYTE_W-1:0]    ptr_w;

    logic                 ram_we_q;
    logic [BYTE_W-1:0]    ram_waddr_q, ram_wdata_q;
    logic [EE_ADDR_W-1:0] ee_addr_q;
    logic                 ee_ld_q;
    logic                 ee_prog_q;
    logic [EE_ADDR_W-1:0] ee_prog_addr_q;
    logic [BYTE_W-1:0]    ee_prog_data_q;
    logic                 ee_erase_q;
    logic [EE_PAGE_W-1:0] ee_page_q;

    // events from the bit engine pass only while no erase is pending
    assign open_q  = !busy_q;
    assign g_start = evt_start && open_q;
    assign g_addr  = evt_addr  && open_q;
    assign g_byte  = evt_byte  && open_q;
    assign g_stop  = evt_stop  && open_q;
    assign g_take  = rd_take   && open_q && rd_active;

    assign erase_fire = g_byte && wr_active && first_byte && !g_start && !g_addr && !g_stop
                        && (rx_byte == ERASE_CMD) && cfg_byte[CFG_BIT];

    smbd_collector #(
        .MAX_BYTES (MAX_BYTES),
        .RAM_LAST  (RAM_LAST)
    ) u_coll (
        .clk        (clk),
        .rst        (rst),
        .ev_start   (g_start),
        .ev_addr    (g_addr),
        .ev_rnw     (evt_rnw),
        .ev_byte    (g_byte),
        .rx_byte    (rx_byte),
        .ev_stop    (g_stop),
        .abort      (erase_fire),
        .wr_active  (wr_active),
        .rd_active  (rd_active),
        .first_byte (first_byte),
        .act        (act)
    );

    smbd_ptr #(
        .W    (BYTE_W),
        .LAST (RAM_LAST)
    ) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ld     (act.kind == ACT_PTR),
        .ld_val (act.cmd),
        .inc    (g_take),
        .ptr    (ptr_w)
    );

    smbd_regfile #(
        .W        (BYTE_W),
        .AW       (BYTE_W),
        .DEPTH    (DEPTH),
        .CFG_ADDR (CFG_ADDR)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (act.kind == ACT_RAMWR),
        .waddr (act.cmd),
        .wdata (act.arg),
        .raddr (ptr_w),
        .rdata (rd_byte),
        .cfg   (cfg_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_we_q       <= 1'b0;
            ram_waddr_q    <= '0;
            ram_wdata_q    <= '0;
            ee_addr_q      <= EE_BASE;
            ee_ld_q        <= 1'b0;
            ee_prog_q      <= 1'b0;
            ee_prog_addr_q <= '0;
            ee_prog_data_q <= '0;
            ee_erase_q     <= 1'b0;
            ee_page_q      <= '0;
            busy_q         <= 1'b0;
        end else begin
            ram_we_q   <= 1'b0;
            ee_ld_q    <= 1'b0;
            ee_prog_q  <= 1'b0;
            ee_erase_q <= 1'b0;
            unique case (act.kind)
                ACT_RAMWR: begin
                    ram_we_q    <= 1'b1;
                    ram_waddr_q <= act.cmd;
                    ram_wdata_q <= act.arg;
                end
                ACT_EEPROG: begin
                    ee_prog_q      <= 1'b1;
                    ee_prog_addr_q <= ee_addr_q;
                    ee_prog_data_q <= act.arg;
                    ee_addr_q      <= ee_step(ee_addr_q);
                end
                ACT_EEADDR: begin
                    ee_ld_q   <= 1'b1;
                    ee_addr_q <= {act.cmd, act.arg};
                end
                default: ;
            endcase
            if (erase_fire) begin
                ee_erase_q <= 1'b1;
                ee_page_q  <= ee_page(ee_addr_q);
                busy_q     <= 1'b1;
            end else if (erase_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign ack_out       = !busy_q;
    assign ptr           = ptr_w;
    assign ram_we        = ram_we_q;
    assign ram_waddr     = ram_waddr_q;
    assign ram_wdata     = ram_wdata_q;
    assign ee_addr       = ee_addr_q;
    assign ee_addr_ld    = ee_ld_q;
    assign ee_prog       = ee_prog_q;
    assign ee_prog_addr  = ee_prog_addr_q;
    assign ee_prog_data  = ee_prog_data_q;
    assign ee_erase      = ee_erase_q;
    assign ee_erase_page = ee_page_q;
    assign erase_busy    = busy_q;

endmodule

// File: rtl/smbd_chk.sv
module smbd_chk (
    input logic        clk,
    input logic        rst,
    input logic        erase_done,
    input logic        ack_out,
    input logic [7:0]  ptr,
    input logic        ram_we,
    input logic [15:0] ee_addr,
    input logic        ee_addr_ld,
    input logic        ee_prog,
    input logic        ee_erase,
    input logic        erase_busy
);

    // R8
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        erase_busy |-> !ack_out);

    // R8
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !erase_busy |-> ack_out);

    // R7
    erase_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ee_erase |-> erase_busy);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_busy && !erase_done) |=> erase_busy);

    // R8
    busy_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        erase_busy |=> $stable(ptr));

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= 8'hDF);

    // R6
    ee_window_chk: assert property (@(posedge clk) disable iff (rst)
        ee_addr[15:10] == 6'b111110);

    // R9
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_we, ee_addr_ld, ee_prog, ee_erase}));

endmodule

bind smbus_cmd_decoder smbd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .erase_done (erase_done),
    .ack_out    (ack_out),
    .ptr        (ptr),
    .ram_we     (ram_we),
    .ee_addr    (ee_addr),
    .ee_addr_ld (ee_addr_ld),
    .ee_prog    (ee_prog),
    .ee_erase   (ee_erase),
    .erase_busy (erase_busy)
);

// File: tb/smbus_cmd_decoder_tb.sv
`timescale 1ns/1ps
module smbus_cmd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_start = 0, evt_addr = 0, evt_rnw = 0, evt_byte = 0;
    logic [7:0]  rx_byte = 0;
    logic        evt_stop = 0, rd_take = 0, erase_done = 0;
    logic        ack_out;
    logic [7:0]  rd_byte, ptr, ram_waddr, ram_wdata, ee_prog_data;
    logic        ram_we, ee_addr_ld, ee_prog, ee_erase, erase_busy;
    logic [15:0] ee_addr, ee_prog_addr;
    logic [4:0]  ee_erase_page;

    always #2 clk = ~clk;

    smbus_cmd_decoder dut_i (
        .clk(clk), .rst(rst),
        .evt_start(evt_start), .evt_addr(evt_addr), .evt_rnw(evt_rnw),
        .evt_byte(evt_byte), .rx_byte(rx_byte), .evt_stop(evt_stop),
        .rd_take(rd_take), .erase_done(erase_done),
        .ack_out(ack_out), .rd_byte(rd_byte), .ptr(ptr),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .ee_addr(ee_addr), .ee_addr_ld(ee_addr_ld),
        .ee_prog(ee_prog), .ee_prog_addr(ee_prog_addr), .ee_prog_data(ee_prog_data),
        .ee_erase(ee_erase), .ee_erase_page(ee_erase_page),
        .erase_busy(erase_busy)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // behavioural reference state
    logic [7:0]  m_mem [0:223];
    logic [7:0]  m_q [$];
    logic [7:0]  m_ptr = 0;
    logic [15:0] m_ee = 16'hF800;
    bit          m_wr = 0, m_rd = 0, m_busy = 0;
    bit          e_we, e_ld, e_prog, e_erase;
    logic [7:0]  e_waddr, e_wdata, e_pdata;
    logic [15:0] e_paddr;
    logic [4:0]  e_page;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_decode();
        if (m_q.size() == 1 && m_q[0] <= 8'hDF) begin
            m_ptr = m_q[0];
        end else if (m_q.size() == 2 && m_q[0] <= 8'hDF) begin
            m_mem[m_q[0]] = m_q[1];
            e_we = 1; e_waddr = m_q[0]; e_wdata = m_q[1];
        end else if (m_q.size() == 2 && m_q[0] >= 8'hF8 && m_q[0] <= 8'hFB) begin
            e_prog = 1; e_paddr = m_ee; e_pdata = m_q[1];
            m_ee = 16'hF800 + 16'((int'(m_ee) - 'hF800 + 1) % 1024);
        end else if (m_q.size() == 3 && m_q[0] >= 8'hF8 && m_q[0] <= 8'hFB) begin
            e_ld = 1;
            m_ee = {m_q[0], m_q[1]};
        end
    endtask

    task automatic model_step(input bit s, a, rw, b, input logic [7:0] d,
                              input bit p, tk, dn);
        e_we = 0; e_ld = 0; e_prog = 0; e_erase = 0;
        if (m_busy) begin
            if (dn) m_busy = 0;
        end else if (s) begin
            m_wr = 0; m_rd = 0; m_q.delete();
        end else if (a) begin
            m_wr = !rw; m_rd = rw; m_q.delete();
        end else if (p) begin
            if (m_wr) model_decode();
            m_wr = 0; m_rd = 0; m_q.delete();
        end else if (b && m_wr) begin
            if (m_q.size() == 0 && d == 8'hFE && m_mem[8'h90][2]) begin
                e_erase = 1; e_page = m_ee[9:5]; m_busy = 1; m_wr = 0;
            end else if (m_q.size() < 4) begin
                m_q.push_back(d);
            end
        end else if (tk && m_rd) begin
            m_ptr = (m_ptr == 8'hDF) ? 8'h00 : m_ptr + 8'h01;
        end
    endtask

    task automatic compare_all();
        chk("R2", "ptr", 32'(ptr), 32'(m_ptr));
        chk("R4", "rd_byte", 32'(rd_byte), 32'(m_mem[m_ptr]));
        chk("R8", "erase_busy", 32'(erase_busy), 32'(m_busy));
        chk("R8", "ack_out", 32'(ack_out), 32'(!m_busy));
        chk("R3", "ram_we", 32'(ram_we), 32'(e_we));
        if (e_we) begin
            chk("R3", "ram_waddr", 32'(ram_waddr), 32'(e_waddr));
            chk("R3", "ram_wdata", 32'(ram_wdata), 32'(e_wdata));
        end
        chk("R5", "ee_addr", 32'(ee_addr), 32'(m_ee));
        chk("R5", "ee_addr_ld", 32'(ee_addr_ld), 32'(e_ld));
        chk("R6", "ee_prog", 32'(ee_prog), 32'(e_prog));
        if (e_prog) begin
            chk("R6", "ee_prog_addr", 32'(ee_prog_addr), 32'(e_paddr));
            chk("R6", "ee_prog_data", 32'(ee_prog_data), 32'(e_pdata));
        end
        chk("R7", "ee_erase", 32'(ee_erase), 32'(e_erase));
        if (e_erase) chk("R7", "ee_erase_page", 32'(ee_erase_page), 32'(e_page));
    endtask

    // one clock: drive at the falling edge, model after the rising edge, compare at the next fall
    task automatic cyc(input bit s, a, rw, b, input logic [7:0] d, input bit p, tk, dn);
        evt_start = s; evt_addr = a; evt_rnw = rw; evt_byte = b; rx_byte = d;
        evt_stop = p; rd_take = tk; erase_done = dn;
        @(posedge clk);
        model_step(s, a, rw, b, d, p, tk, dn);
        @(negedge clk);
        evt_start = 0; evt_addr = 0; evt_rnw = 0; evt_byte = 0; rx_byte = 0;
        evt_stop = 0; rd_take = 0; erase_done = 0;
        compare_all();
    endtask

    task automatic idle();            cyc(0,0,0,0,8'h00,0,0,0); endtask
    task automatic ev_start();        cyc(1,0,0,0,8'h00,0,0,0); endtask
    task automatic ev_addr(input bit rw); cyc(0,1,rw,0,8'h00,0,0,0); endtask
    task automatic ev_byte(input logic [7:0] v); cyc(0,0,0,1,v,0,0,0); endtask
    task automatic ev_stop();         cyc(0,0,0,0,8'h00,1,0,0); endtask
    task automatic ev_take();         cyc(0,0,0,0,8'h00,0,1,0); endtask
    task automatic ev_done();         cyc(0,0,0,0,8'h00,0,0,1); endtask

    task automatic wr(input int n, input logic [7:0] b0, input logic [7:0] b1 = 0,
                      input logic [7:0] b2 = 0, input logic [7:0] b3 = 0);
        logic [7:0] bv [4];
        bv = '{b0, b1, b2, b3};
        ev_start();
        ev_addr(1'b0);
        for (int i = 0; i < n; i++) ev_byte(bv[i]);
        ev_stop();
        idle();
    endtask

    task automatic rd(input int n);
        ev_start();
        ev_addr(1'b1);
        for (int i = 0; i < n; i++) ev_take();
        ev_stop();
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 224; i++) m_mem[i] = 8'h00;
        e_we = 0; e_ld = 0; e_prog = 0; e_erase = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "ptr", 32'(ptr), 32'h00);
        chk("R1", "ee_addr", 32'(ee_addr), 32'hF800);
        chk("R1", "erase_busy", 32'(erase_busy), 32'h0);
        chk("R1", "ack_out", 32'(ack_out), 32'h1);
        chk("R1", "rd_byte", 32'(rd_byte), 32'h00);
        chk("R1", "pulses", 32'({ram_we, ee_addr_ld, ee_prog, ee_erase}), 32'h0);
        idle();

        // R3 register writes, including the top address and the erase enable
        wr(2, 8'h10, 8'hA5);
        wr(2, 8'hDF, 8'h3C);
        wr(2, 8'h11, 8'h5E);
        wr(2, 8'h90, 8'h04);

        // R2 / R4 pointer load and sequential read
        wr(1, 8'h10);
        rd(2);
        chk("R4", "ptr after two takes", 32'(ptr), 32'h12);
        wr(1, 8'hDF);
        chk("R4", "rd_byte at top", 32'(rd_byte), 32'h3C);
        rd(1);
        chk("R4", "ptr wrap", 32'(ptr), 32'h00);

        // R2 out-of-range single byte leaves the pointer alone
        wr(1, 8'h11);
        wr(1, 8'hE5);
        chk("R2", "ptr kept", 32'(ptr), 32'h11);
        wr(2, 8'hE0, 8'h11);

        // R5 / R6 nonvolatile address load and byte programming
        wr(3, 8'hF9, 8'h23, 8'h77);
        chk("R5", "ee_addr loaded", 32'(ee_addr), 32'hF923);
        wr(2, 8'hF9, 8'h5A);
        wr(2, 8'hFA, 8'h6B);
        chk("R6", "ee_addr advanced", 32'(ee_addr), 32'hF925);
        wr(3, 8'hFB, 8'hFF, 8'h00);
        wr(2, 8'hFB, 8'h01);
        chk("R6", "ee_addr wrap", 32'(ee_addr), 32'hF800);

        // R9 repeated start discards, overflow discards
        ev_start(); ev_addr(1'b0); ev_byte(8'h20); ev_byte(8'h99);
        ev_start();
        chk("R9", "ram_we after restart", 32'(ram_we), 32'h0);
        ev_stop(); idle();
        wr(4, 8'h20, 8'h01, 8'h02, 8'h03);
        chk("R9", "ram_we after overflow", 32'(ram_we), 32'h0);
        wr(1, 8'h20);
        chk("R9", "reg 0x20 untouched", 32'(rd_byte), 32'h00);

        // R7 erase refused while the enable bit is clear
        wr(2, 8'h90, 8'h00);
        ev_start(); ev_addr(1'b0); ev_byte(8'hFE);
        chk("R7", "no erase when disabled", 32'(ee_erase), 32'h0);
        ev_stop(); idle();
        wr(2, 8'h90, 8'h04);

        // R7 / R8 erase, refusal while busy, completion
        wr(3, 8'hF9, 8'h40, 8'h00);
        ev_start(); ev_addr(1'b0); ev_byte(8'hFE);
        chk("R7", "erase pulse", 32'(ee_erase), 32'h1);
        chk("R7", "erase page", 32'(ee_erase_page), 32'h0A);
        ev_stop();
        chk("R8", "nack while busy", 32'(ack_out), 32'h0);
        wr(2, 8'h10, 8'h77);
        wr(1, 8'h05);
        rd(1);
        chk("R8", "ptr frozen", 32'(ptr), 32'h20);
        repeat (5) idle();
        ev_done();
        chk("R8", "busy cleared", 32'(erase_busy), 32'h0);
        chk("R8", "ack restored", 32'(ack_out), 32'h1);
        wr(1, 8'h10);
        chk("R8", "write during busy dropped", 32'(rd_byte), 32'hA5);
        rd(1);
        repeat (3) idle();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule